// File: doc/BRIEF.md
# Banked register window translator

This block lets a host reach a large register space through a narrow window of 256 word offsets. The register space is addressed by a device number and a 16-bit register number. The host first stores the upper part of the full internal address in a bank register. The bank register is sticky and occupies the top offset of the window. The host then reads or writes one of the 255 remaining offsets. The block joins the stored bank and the offset into the full internal address and forwards the access to an internal register array. It returns the result on a 32-bit data word one cycle later.

The array covers a contiguous run of `NREG` full addresses starting at `MAP_BASE`. An address outside that run reads as all ones, and a write to it is dropped. An instance built with `PRESENT` cleared stands for a window whose base is absent. Such an instance answers every access with an error and holds no state.

Top module: `banked_window`

## Requirements
- R1: After reset the bank register holds zero, every array register holds zero, and `rsp_valid` is low.
- R2: A write to offset 0xFF (byte offset 0x3FC) stores `req_wdata[BANK_W-1:0]` as the bank. A read of offset 0xFF returns the stored bank zero-extended to 32 bits. The bank holds its value until the next write to offset 0xFF, across any number of other accesses.
- R3: An access at offset o below 0xFF targets the full address bank*256 + o. The full address of device d and register r is d*65536 + r, so its bank is that value divided by 256 and its offset is the low 8 bits. A read of a mapped address returns the stored value in bits 15:0 with bits 31:16 zero.
- R4: A window write stores only `req_wdata[15:0]`, and every write response carries `rsp_rdata` = 0.
- R5: A read of an unmapped full address returns 0x0000FFFF. A write to one changes no register.
- R6: Every request accepted on a rising edge gets exactly one response, with `rsp_valid` high on the next edge only. A present instance never raises `rsp_err`.
- R7: An instance with `PRESENT` = 0 answers every request with `rsp_err` = 1 and `rsp_rdata` = 0.
- R8: A full address whose low byte is 0xFF can never be reached. Offset 0xFF always selects the bank register and never the array, whatever the bank holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request strobe, one access per cycle |
| req_we | input | 1 | 1 = write, 0 = read |
| req_off | input | OFF_W | Window word offset; 0xFF is the bank register |
| req_wdata | input | BUS_W | Write data |
| rsp_valid | output | 1 | Response strobe, one cycle after the request |
| rsp_rdata | output | BUS_W | Read data, low 16 bits used for window reads |
| rsp_err | output | 1 | Access rejected, instance absent |

## Verification
The bound properties hold on every cycle. They cover the one-cycle request-to-response pairing, the clear upper half of every response, the zero bank after reset, and the rule that the bank moves only on a write to offset 0xFF. They also cover the error and zero-data answer of an absent instance. Address composition, the all-ones answer for unmapped addresses and the dropped write there, the truncation of bank and data words, and the unreachable 0xFF-ending register depend on the contents of the array. Only the bench's scenarios show those, comparing against its own model on every clock.

// File: rtl/banked_window.sv
module banked_window #(
  parameter int ADDR_W = 21,
  parameter int OFF_W = 8,
  parameter int DATA_W = 16,
  parameter int BUS_W = 32,
  parameter int NREG = 16,
  parameter logic [ADDR_W-1:0] MAP_BASE = 21'h1F00F8,
  parameter bit PRESENT = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_we,
  input  logic [OFF_W-1:0] req_off,
  input  logic [BUS_W-1:0] req_wdata,
  output logic             rsp_valid,
  output logic [BUS_W-1:0] rsp_rdata,
  output logic             rsp_err
);
  localparam int BANK_W = ADDR_W - OFF_W;
  localparam int IDX_W = (NREG > 1) ? $clog2(NREG) : 1;
  localparam logic [OFF_W-1:0] BANK_OFF = '1;
  localparam logic [ADDR_W:0] LO = {1'b0, MAP_BASE};
  localparam logic [ADDR_W:0] HI = LO + (ADDR_W+1)'(NREG);

  logic [BANK_W-1:0] bank_q;
  logic [DATA_W-1:0] regs [NREG];

  logic [ADDR_W:0] full_x;
  logic            is_bank, hit;
  logic [IDX_W-1:0] idx;
  logic            unused_wdata;

  assign full_x  = {1'b0, bank_q, req_off};
  assign is_bank = (req_off == BANK_OFF);
  assign hit     = !is_bank && (full_x >= LO) && (full_x < HI);
  assign idx     = IDX_W'(full_x - LO);
  assign unused_wdata = &{1'b0, req_wdata[BUS_W-1:DATA_W]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bank_q    <= '0;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
      rsp_err   <= 1'b0;
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else begin
      rsp_valid <= req_valid;
      rsp_err   <= 1'b0;
      rsp_rdata <= '0;
      if (req_valid) begin
        if (!PRESENT) begin
          rsp_err <= 1'b1;
        end else if (is_bank) begin
          if (req_we) bank_q <= req_wdata[BANK_W-1:0];
          else        rsp_rdata <= BUS_W'(bank_q);
        end else if (req_we) begin
          if (hit) regs[idx] <= req_wdata[DATA_W-1:0];
        end else begin
          rsp_rdata <= hit ? BUS_W'(regs[idx]) : BUS_W'({DATA_W{1'b1}});
        end
      end
    end
  end
endmodule

module banked_window_chk #(
  parameter int OFF_W = 8,
  parameter int BUS_W = 32,
  parameter int BANK_W = 13,
  parameter bit PRESENT = 1'b1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_we,
  input logic [OFF_W-1:0]  req_off,
  input logic              rsp_valid,
  input logic [BUS_W-1:0]  rsp_rdata,
  input logic              rsp_err,
  input logic [BANK_W-1:0] bank_q
);
  // R1
  bank_after_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (bank_q == '0));

  // R2
  bank_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && req_we && req_off == '1) |=> $stable(bank_q));

  // R3
  upper_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_rdata[BUS_W-1:16] == '0));

  // R6
  resp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);

  // R6
  no_spurious_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);

  // R6
  present_no_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && PRESENT) |-> !rsp_err);

  // R7
  absent_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !PRESENT) |-> (rsp_err && rsp_rdata == '0));

  // R4
  write_resp_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_we) |=> (rsp_rdata == '0));
endmodule

bind banked_window banked_window_chk #(
  .OFF_W(OFF_W), .BUS_W(BUS_W), .BANK_W(BANK_W), .PRESENT(PRESENT)
) chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_we(req_we),
  .req_off(req_off), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
  .rsp_err(rsp_err), .bank_q(bank_q)
);

// File: tb/sim_banked_window.sv
module sim_banked_window;
  localparam int BASE = 32'h1F00F8;
  localparam int NREG = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_we = 1'b0;
  logic [7:0] req_off = '0;
  logic [31:0] req_wdata = '0;
  logic rsp_valid, rsp_err, rsp_valid1, rsp_err1;
  logic [31:0] rsp_rdata, rsp_rdata1;

  always #4 clk = ~clk;

  banked_window u0 (.clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_we(req_we),
    .req_off(req_off), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata), .rsp_err(rsp_err));

  banked_window #(.PRESENT(1'b0)) u1 (.clk(clk), .rst_n(rst_n), .req_valid(req_valid),
    .req_we(req_we), .req_off(req_off), .req_wdata(req_wdata), .rsp_valid(rsp_valid1),
    .rsp_rdata(rsp_rdata1), .rsp_err(rsp_err1));

  int checks = 0, fails = 0;
  int m_bank;
  int m_regs [NREG];
  bit done = 0;

  function automatic int bank_of(input int dev, input int reg_n);
    return ((dev << 16) | reg_n) >> 8;
  endfunction

  task automatic cmp(input string tag, input logic [33:0] act, input logic [33:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual v/e/d=%h expected %h", tag, act, exp);
    end
  endtask

  task automatic apply(input bit v, input bit we, input int off, input int wd, input string tag);
    logic [31:0] ed;
    int full;
    ed = 32'h0;
    full = m_bank * 256 + off;
    if (v) begin
      if (off == 255) begin
        if (we) m_bank = wd & 32'h1FFF;
        else    ed = m_bank;
      end else if (full >= BASE && full < BASE + NREG) begin
        if (we) m_regs[full - BASE] = wd & 32'hFFFF;
        else    ed = m_regs[full - BASE];
      end else if (!we) begin
        ed = 32'h0000FFFF;
      end
    end
    req_valid = v; req_we = we; req_off = off[7:0]; req_wdata = wd;
    @(negedge clk);
    cmp(tag, {rsp_valid, rsp_err, rsp_rdata}, {v, 1'b0, ed});
    cmp("R7", {rsp_valid1, rsp_err1, rsp_rdata1}, {v, v, 32'h0});
    req_valid = 1'b0;
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    int s;
    m_bank = 0;
    for (int i = 0; i < NREG; i++) m_regs[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    cmp("R1 idle", {rsp_valid, rsp_err, rsp_rdata}, 34'h0);
    apply(1, 0, 255, 0, "R1 bank reset");
    apply(1, 0, 8'h10, 0, "R5 unmapped bank0");
    apply(1, 1, 8'h05, 32'h1234, "R5 unmapped write");
    apply(1, 0, 8'h05, 0, "R5 unmapped readback");
    apply(1, 1, 255, 32'hFFFF_0000 | bank_of(32'h1F, 32'h00F8), "R2 bank write truncated");
    apply(1, 0, 255, 0, "R2 bank readback");
    apply(1, 0, 8'hF8, 0, "R1 array reset");
    for (int o = 8'hF8; o < 8'hFF; o++) apply(1, 1, o, 32'hABCD_0000 | (o * 257), "R4 write low half");
    apply(0, 0, 0, 0, "R6 idle");
    for (int o = 8'hF8; o < 8'hFF; o++) apply(1, 0, o, 0, "R3 read sticky bank");
    apply(1, 0, 8'hF7, 0, "R5 below base");
    apply(1, 1, 255, 32'h1F01, "R8 offset ff is bank");
    apply(1, 0, 255, 0, "R8 bank moved");
    for (int o = 0; o < 9; o++) apply(1, 1, o, 32'h5A00 + o, "R3 next bank write");
    for (int o = 0; o < 9; o++) apply(1, 0, o, 0, "R5 top edge read");
    apply(1, 1, 255, bank_of(32'h1F, 32'h00F8), "R2 bank back");
    for (int o = 8'hF8; o < 8'hFF; o++) apply(1, 0, o, 0, "R5 unmapped writes left data");
    s = 7;
    for (int k = 0; k < 400; k++) begin
      int op, off;
      s = (s * 1103515245 + 12345) & 32'h7FFFFFFF;
      op = (s >> 8) & 15;
      off = (op == 0) ? 255 : ((op < 8) ? (8'hF8 + ((s >> 12) & 7)) : ((s >> 12) & 15));
      if (op == 0) apply(1, 1, 255, 32'h1F00 + ((s >> 16) & 1), "R2 random bank");
      else if (op == 15) apply(0, 0, 0, 0, "R6 random idle");
      else apply(1, (s >> 20) & 1, off, s, "R3 random access");
    end
    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule